// File: doc/BRIEF.md
# MSI-X Capability Registers

This block is the MSI-X capability structure seen in a function's configuration space. A configuration access decoder above it hands over dword-indexed reads and byte-enabled writes, already offset from the capability base. The structure is three dwords long:

- A header dword holding the capability ID, the next-capability pointer and the message control word.
- A dword that locates the vector table.
- A dword that locates the pending-bit array.

Almost every field is fixed by parameters. Software can change only two control bits: the function mask and the global enable. Both are driven straight to the vector table logic.

A write that re-opens delivery raises a one-cycle rescan strobe. Re-opening means clearing the function mask, or turning the enable on. The vector table uses the strobe to replay vectors that went pending while delivery was blocked.

Top module: `msix_cap_regs`

## Requirements
- R1: Byte 0 of dword 0 reads the capability ID parameter (default 0x11), and byte 1 reads the next pointer parameter (default 0x70). Writes to either byte change nothing.
- R2: Bits 10:0 of the message control word (dword 0 bits 26:16) read NUM_VEC-1, and bits 13:11 (dword 0 bits 29:27) read 0. All of these bits ignore writes.
- R3: A write to dword 0 with byte enable 3 set loads data bit 31 into the enable and data bit 30 into the function mask. The outputs and the read value (dword 0 bits 31 and 30) show the new values from the clock edge that takes the write.
- R4: Dword 1 reads BAR_IDX in bits 2:0 with a table offset of zero, and it ignores writes.
- R5: Dword 2 reads NUM_VEC*16 ORed with BAR_IDX, and it ignores writes.
- R6: After reset, the enable and the function mask are both 0 and the rescan strobe is low.
- R7: A write that changes the function mask from 1 to 0 raises the rescan strobe for the cycle after the write edge.
- R8: A write that changes the enable from 0 to 1 raises the rescan strobe for the cycle after the write edge. If the same write also clears the mask, the strobe still lasts exactly one cycle.
- R9: The rescan strobe stays low for every other write. This includes setting the mask, clearing the enable, and rewriting the current values.
- R10: A read returns its data on rd_data on the clock edge after rd_en is sampled. Dword index 3 reads as zero.
- R11: Writes with byte enable 3 clear, and writes to dword indexes 1 to 3, leave the enable and the mask unchanged. A multi-byte write is merged one byte at a time, starting at the lowest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 2 | Dword index of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 2 | Dword index of the read |
| rd_data | output | 32 | Registered read data |
| msix_enable | output | 1 | Global delivery enable |
| func_mask | output | 1 | Function-wide mask |
| rescan_pulse | output | 1 | One-cycle request to replay pending vectors |

## Verification
Every result in this block appears one edge after its stimulus. Control bits and the rescan strobe change at the edge that takes a write. Read data settles at the edge after rd_en. The bench drives inputs on the falling edge and samples on the next falling edge, so every check lands half a period after the edge that produced the result. Within that window it compares the strobe, the control outputs and the read dword against its own model of the previous state.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;

  localparam int DW_BYTES   = 4;
  localparam int IDX_W      = 2;
  localparam int SIZE_W     = 11;
  localparam int BIR_W      = 3;
  localparam int CTRL_HI_OFS = 3;            // byte offset of the upper control byte
  localparam logic [7:0] CTRL_HI_WMASK = 8'hC0;

  typedef logic [IDX_W-1:0] dw_idx_t;

  typedef enum logic [IDX_W-1:0] {
    DW_HEADER = 2'd0,
    DW_TABLE  = 2'd1,
    DW_PBA    = 2'd2,
    DW_RSVD   = 2'd3
  } dw_sel_e;

  function automatic logic [SIZE_W-1:0] size_field(int n);
    return SIZE_W'(n - 1);
  endfunction

  function automatic logic [31:0] table_word(int bar);
    return {29'd0, BIR_W'(bar)};
  endfunction

  function automatic logic [31:0] pba_word(int n, int bar);
    return (32'(n) << 4) | {29'd0, BIR_W'(bar)};
  endfunction

  function automatic logic [31:0] header_word(logic [7:0] id, logic [7:0] nxt,
                                               int n, logic en, logic fm);
    return {en, fm, 3'b000, size_field(n), nxt, id};
  endfunction

  function automatic logic [7:0] merge_byte(logic [7:0] old_b, logic [7:0] new_b,
                                            logic [7:0] wmask);
    return (old_b & ~wmask) | (new_b & wmask);
  endfunction

endpackage

// File: rtl/msix_wr_merge.sv
module msix_wr_merge
  import msix_cap_pkg::*;
(
  input  logic          wr_en,
  input  dw_idx_t       wr_idx,
  input  logic [3:0]    wr_be,
  input  logic [31:0]   wr_data,
  input  logic          cur_en,
  input  logic          cur_fm,
  output logic          lane_hit,
  output logic          nxt_en,
  output logic          nxt_fm
);

  logic [7:0] ctrl_b;

  // Apply enabled bytes one at a time, lowest address first.
  always_comb begin
    ctrl_b   = {cur_en, cur_fm, 6'd0};
    lane_hit = 1'b0;
    for (int b = 0; b < DW_BYTES; b++) begin
      if (wr_en && wr_be[b]) begin
        if ({wr_idx, 2'(b)} == 4'(CTRL_HI_OFS)) begin
          ctrl_b   = merge_byte(ctrl_b, wr_data[8*b +: 8], CTRL_HI_WMASK);
          lane_hit = 1'b1;
        end
      end
    end
    nxt_en = ctrl_b[7];
    nxt_fm = ctrl_b[6];
  end

endmodule

// File: rtl/msix_ctrl_bits.sv
module msix_ctrl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic lane_hit,
  input  logic nxt_en,
  input  logic nxt_fm,
  output logic enable,
  output logic fmask,
  output logic unmask_evt,
  output logic rescan
);

  logic mask_released;
  logic enable_raised;

  assign mask_released = lane_hit && fmask && !nxt_fm;
  assign enable_raised = lane_hit && !enable && nxt_en;
  assign unmask_evt    = mask_released || enable_raised;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      fmask  <= 1'b0;
      rescan <= 1'b0;
    end else begin
      rescan <= unmask_evt;
      if (lane_hit) begin
        enable <= nxt_en;
        fmask  <= nxt_fm;
      end
    end
  end

endmodule

// File: rtl/msix_rd_port.sv
module msix_rd_port
  import msix_cap_pkg::*;
#(
  parameter int         NUM_VEC  = 20,
  parameter int         BAR_IDX  = 3,
  parameter logic [7:0] CAP_ID   = 8'h11,
  parameter logic [7:0] NEXT_PTR = 8'h70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  dw_idx_t     rd_idx,
  input  logic        enable,
  input  logic        fmask,
  output logic [31:0] rd_data
);

  localparam logic [31:0] TABLE_DW = table_word(BAR_IDX);
  localparam logic [31:0] PBA_DW   = pba_word(NUM_VEC, BAR_IDX);

  logic [31:0] rd_mux;

  always_comb begin
    unique case (dw_sel_e'(rd_idx))
      DW_HEADER: rd_mux = header_word(CAP_ID, NEXT_PTR, NUM_VEC, enable, fmask);
      DW_TABLE:  rd_mux = TABLE_DW;
      DW_PBA:    rd_mux = PBA_DW;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 32'd0;
    else if (rd_en) rd_data <= rd_mux;
  end

endmodule

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
  import msix_cap_pkg::*;
#(
  parameter int         NUM_VEC  = 20,
  parameter int         BAR_IDX  = 3,
  parameter logic [7:0] CAP_ID   = 8'h11,
  parameter logic [7:0] NEXT_PTR = 8'h70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_idx,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_idx,
  output logic [31:0] rd_data,
  output logic        msix_enable,
  output logic        func_mask,
  output logic        rescan_pulse
);

  logic lane_hit;
  logic nxt_en;
  logic nxt_fm;
  logic unmask_evt;

  msix_wr_merge u_merge (
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .cur_en   (msix_enable),
    .cur_fm   (func_mask),
    .lane_hit (lane_hit),
    .nxt_en   (nxt_en),
    .nxt_fm   (nxt_fm)
  );

  msix_ctrl_bits u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_hit   (lane_hit),
    .nxt_en     (nxt_en),
    .nxt_fm     (nxt_fm),
    .enable     (msix_enable),
    .fmask      (func_mask),
    .unmask_evt (unmask_evt),
    .rescan     (rescan_pulse)
  );

  msix_rd_port #(
    .NUM_VEC  (NUM_VEC),
    .BAR_IDX  (BAR_IDX),
    .CAP_ID   (CAP_ID),
    .NEXT_PTR (NEXT_PTR)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .enable  (msix_enable),
    .fmask   (func_mask),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/msix_cap_regs_chk.sv
module msix_cap_regs_chk
  import msix_cap_pkg::*;
#(
  parameter int         NUM_VEC  = 20,
  parameter int         BAR_IDX  = 3,
  parameter logic [7:0] CAP_ID   = 8'h11,
  parameter logic [7:0] NEXT_PTR = 8'h70
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [1:0]  rd_idx,
  input logic [31:0] rd_data,
  input logic        msix_enable,
  input logic        func_mask,
  input logic        rescan_pulse,
  input logic        lane_hit,
  input logic        nxt_en,
  input logic        nxt_fm,
  input logic        unmask_evt
);

  localparam logic [15:0] HDR_LO  = {NEXT_PTR, CAP_ID};
  localparam logic [13:0] CTRL_RO = {3'b000, 11'(NUM_VEC - 1)};
  localparam logic [31:0] PBA_EXP = 32'(NUM_VEC * 16 + BAR_IDX);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!msix_enable && !func_mask && !rescan_pulse)); // R6

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lane_hit |=> (msix_enable == $past(nxt_en)) && (func_mask == $past(nxt_fm))); // R3

  AST_MASK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_hit && func_mask && !nxt_fm) |=> rescan_pulse); // R7

  AST_ENABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_hit && !msix_enable && nxt_en) |=> rescan_pulse); // R8

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_pulse |-> ($fell(func_mask) || $rose(msix_enable))); // R9

  AST_NO_EVT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !unmask_evt |=> !rescan_pulse); // R9

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_hit |=> ($stable(msix_enable) && $stable(func_mask))); // R11

  AST_RD_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 2'd0) |=> (rd_data[15:0] == HDR_LO) && (rd_data[29:16] == CTRL_RO)); // R2

  AST_RD_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 2'd1) |=> rd_data == 32'(BAR_IDX)); // R4

  AST_RD_PBA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 2'd2) |=> rd_data == PBA_EXP); // R5

  AST_RD_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 2'd3) |=> rd_data == 32'd0); // R10

endmodule

bind msix_cap_regs msix_cap_regs_chk #(
  .NUM_VEC  (NUM_VEC),
  .BAR_IDX  (BAR_IDX),
  .CAP_ID   (CAP_ID),
  .NEXT_PTR (NEXT_PTR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .rd_idx       (rd_idx),
  .rd_data      (rd_data),
  .msix_enable  (msix_enable),
  .func_mask    (func_mask),
  .rescan_pulse (rescan_pulse),
  .lane_hit     (lane_hit),
  .nxt_en       (nxt_en),
  .nxt_fm       (nxt_fm),
  .unmask_evt   (unmask_evt)
);

// File: tb/msix_cap_regs_tb.sv
module msix_cap_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 20;
  localparam int BAR        = 3;
  localparam logic [7:0] CID = 8'h11;
  localparam logic [7:0] NXT = 8'h70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        msix_enable, func_mask, rescan_pulse;

  int checks = 0;
  int errors = 0;
  bit m_en = 1'b0;
  bit m_fm = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msix_cap_regs #(.NUM_VEC(N_VEC), .BAR_IDX(BAR), .CAP_ID(CID), .NEXT_PTR(NXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_be(wr_be),
    .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .msix_enable(msix_enable), .func_mask(func_mask), .rescan_pulse(rescan_pulse)
  );

  function automatic logic [31:0] exp_read(logic [1:0] idx, bit en, bit fm);
    logic [31:0] v;
    case (idx)
      2'd0: begin
        v = 32'(CID) + (32'(NXT) << 8) + (32'(N_VEC - 1) << 16);
        if (fm) v = v + 32'h4000_0000;
        if (en) v = v + 32'h8000_0000;
      end
      2'd1: v = 32'(BAR);
      2'd2: v = 32'(N_VEC) * 16 + 32'(BAR);
      default: v = 32'd0;
    endcase
    return v;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(logic [1:0] idx, logic [3:0] be, logic [31:0] d, string req);
    bit nen, nfm, pulse;
    nen = m_en; nfm = m_fm;
    if (idx == 2'd0 && be[3]) begin nen = d[31]; nfm = d[30]; end
    pulse = (m_fm && !nfm) || (!m_en && nen);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_en = nen; m_fm = nfm;
    check({req, " enable"}, 32'(msix_enable), 32'(m_en));
    check({req, " mask"}, 32'(func_mask), 32'(m_fm));
    check({req, " strobe"}, 32'(rescan_pulse), 32'(pulse));
  endtask

  task automatic do_read(logic [1:0] idx, string req);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, exp_read(idx, m_en, m_fm));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 enable", 32'(msix_enable), 32'd0);
    check("R6 mask", 32'(func_mask), 32'd0);
    check("R6 strobe", 32'(rescan_pulse), 32'd0);
    // R1 R2 R4 R5 R10 fixed fields
    do_read(2'd0, "R1 R2 header");
    do_read(2'd1, "R4 table");
    do_read(2'd2, "R5 pba");
    do_read(2'd3, "R10 reserved");
    // R8 enable 0->1 with mask set
    do_write(2'd0, 4'hF, 32'hFFFF_FFFF, "R8 full write");
    do_read(2'd0, "R1 R3 header after write");
    // R11 lane 3 off
    do_write(2'd0, 4'h7, 32'h0000_0000, "R11 lane3 off");
    // R7 mask 1->0 (and enable cleared)
    do_write(2'd0, 4'h8, 32'h0000_0000, "R7 clear both");
    do_write(2'd0, 4'h8, 32'h4000_0000, "R9 set mask");
    // R8 both in one write: single pulse
    do_write(2'd0, 4'h8, 32'h8000_0000, "R8 both events");
    @(negedge clk);
    check("R8 strobe one cycle", 32'(rescan_pulse), 32'd0);
    do_write(2'd0, 4'h8, 32'h8000_0000, "R9 rewrite same");
    // R4 R5 R11 writes to read-only dwords
    do_write(2'd1, 4'hF, 32'hFFFF_FFFF, "R11 table write");
    do_write(2'd2, 4'hF, 32'hFFFF_FFFF, "R11 pba write");
    do_write(2'd3, 4'hF, 32'hFFFF_FFFF, "R11 rsvd write");
    do_read(2'd1, "R4 table after write");
    do_read(2'd2, "R5 pba after write");
    // random mix (R3 R7 R8 R9 R10 R11)
    for (int i = 0; i < 400; i++) begin
      logic [1:0] idx;
      logic [3:0] be;
      logic [31:0] d;
      idx = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) idx = 2'd0;
      be = 4'($urandom);
      d = $urandom;
      if ($urandom_range(0, 1) == 1) do_write(idx, be, d, "R3 random write");
      else do_read(idx, "R10 random read");
    end
    finish_run();
  end

endmodule